// File: doc/BRIEF.md
# FizzBuzz Serial Text Generator

This block writes the FizzBuzz sequence for the numbers 1 to 100 as ASCII text on one asynchronous serial output pin. A multiple of three gives the word "Fizz" and a multiple of five gives "Buzz". A multiple of both gives "FizzBuzz". Any other number is sent as its decimal digits. Every line ends with a carriage return and then a line feed. The block needs no external input other than its clock and reset. It starts sending one clock after reset is released. It stops by itself after the line for the last number.

The block uses no divider and no modulo hardware. The current number is held as binary-coded decimal digits, so each digit becomes a character by prefixing a fixed nibble. Divisibility comes from two residue counters that wrap at three and at five and step together with the number. A line sequencer selects one character at a time and hands it to a bit-level transmitter. It moves on only after the transmitter reports that the frame is complete. The bit period is a parameter, so the same design can run at a real baud rate or with a very short period.

Top module: `fizzbuzz_serial_gen`

## Requirements
- R1: While reset is low, and on the first clock after it, `ser_out` is 1, `busy` is 0 and `finished` is 0.
- R2: For a number divisible by 15 the line text is "FizzBuzz". For one divisible only by 3 it is "Fizz", and for one divisible only by 5 it is "Buzz", each as 8-bit ASCII.
- R3: Any other number is sent as its decimal digits with leading zeros removed. The most significant digit goes first, and each digit is sent as the byte 0x30 plus its value (so 7 gives "7" and 10 gives "10").
- R4: Every line, whether words or digits, ends with 0x0D followed by 0x0A. Lines are sent in order for the numbers 1 through `LAST_NUM`.
- R5: Each character is one frame. The frame is a low start bit, then 8 data bits with the least significant bit first, then one high stop bit. The line is high when no frame is being sent.
- R6: Each of the ten bits of a frame holds `ser_out` steady for exactly `BIT_DIV` clocks.
- R7: `finished` stays 0 until the line feed of the last line has been sent. After that, `finished` stays 1, `ser_out` stays 1 and no further frame starts until reset.
- R8: `busy` is 1 throughout every frame. It is 0 once the block has finished.
- R9: A reset asserted in the middle of a run abandons the run. After reset is released, the output starts again from the line for 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_out | output | 1 | Serial text output, idle high |
| busy | output | 1 | High while a character frame is on the line |
| finished | output | 1 | High after the last line has been sent, until reset |

## Verification
The block has only a clock and a reset as inputs. The assertions therefore assume only that reset is held low for at least one clock edge before the run. They also assume that the internal start request never arrives while a frame is still in progress, and one property checks that assumption. The bench uses a short bit period. It decodes every frame at the pin, with the expected text built from a software model of the sequence. It checks that each bit is steady from the first clock of its period to the last. It releases reset on a falling clock edge. It also applies a second reset part-way through a run to exercise the restart.

// File: rtl/fb_pkg.sv
// Package: shared types and character constants for the FizzBuzz generator.
// Assumes ASCII text; the word table holds "FizzBuzz" with 'F' in the top byte.
package fb_pkg;
    typedef enum logic [1:0] {LINE_NUM, LINE_FIZZ, LINE_BUZZ, LINE_BOTH} line_kind_t;

    localparam logic [7:0]  ASCII_CR  = 8'h0D;
    localparam logic [7:0]  ASCII_LF  = 8'h0A;
    localparam logic [63:0] WORD_TEXT = "FizzBuzz";

    // Returns the character at position pos (0..7) of the word table.
    function automatic logic [7:0] word_char(input int pos);
        logic [7:0] c;
        c = 8'h3F;
        for (int i = 0; i < 8; i++) begin
            if (i == pos) c = WORD_TEXT[8*(7-i) +: 8];
        end
        return c;
    endfunction
endpackage

// File: rtl/fb_bcd_counter.sv
// Module: multi-digit BCD counter, reset value 1.
// Each digit wraps 9 -> 0 and carries into the next digit up. Assumes inc is a
// single-cycle request; the top digit wraps silently.
module fb_bcd_counter #(
    parameter int DIGITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc,
    output logic [DIGITS-1:0][3:0] digit_q
);
    logic [DIGITS-1:0] carry;

    assign carry[0] = inc;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        if (d < DIGITS - 1) begin : g_chain
            assign carry[d+1] = carry[d] && (digit_q[d] == 4'd9);
        end

        // Step one decimal digit when its carry-in is set.
        always_ff @(posedge clk) begin
            if (!rst_n)        digit_q[d] <= (d == 0) ? 4'd1 : 4'd0;
            else if (carry[d]) digit_q[d] <= (digit_q[d] == 4'd9) ? 4'd0 : digit_q[d] + 4'd1;
        end

        // R3: every digit stays a valid decimal value
        a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            digit_q[d] <= 4'd9);
    end
endmodule

// File: rtl/fb_residue.sv
// Module: wrap-around residue counter modulo MOD, reset value INIT.
// Assumes MOD >= 2 and INIT < MOD; steps on inc in lock-step with the number.
module fb_residue #(
    parameter int MOD  = 3,
    parameter int INIT = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc,
    output logic                   is_zero
);
    localparam int W = $clog2(MOD);
    logic [W-1:0] res_q;

    // Count 0..MOD-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   res_q <= W'(INIT);
        else if (inc) res_q <= (res_q == W'(MOD - 1)) ? '0 : res_q + 1'b1;
    end

    assign is_zero = (res_q == '0);

    // R2: the residue never leaves its range
    a_r2_residue_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_q <= W'(MOD - 1));
endmodule

// File: rtl/fb_uart_tx.sv
// Module: 8N1 serial transmitter.
// A start pulse loads a byte while idle. The frame is a low start bit, eight data
// bits sent LSB first and a high stop bit, each BIT_DIV clocks long. done pulses
// for one clock after the stop bit. Assumes start arrives only while busy is low.
module fb_uart_tx #(
    parameter int BIT_DIV = 5208
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       ser_out,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(BIT_DIV);

    logic [CW-1:0] cnt_q;
    logic [3:0]    bit_q;
    logic [9:0]    shreg_q;

    // Bit timing, frame shifting and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '1;
            ser_out <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    shreg_q <= {1'b1, data, 1'b0};
                    ser_out <= 1'b0;
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    busy    <= 1'b1;
                end
            end else if (cnt_q == CW'(BIT_DIV - 1)) begin
                cnt_q <= '0;
                if (bit_q == 4'd9) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    ser_out <= 1'b1;
                end else begin
                    bit_q   <= bit_q + 4'd1;
                    ser_out <= shreg_q[1];
                    shreg_q <= {1'b1, shreg_q[9:1]};
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5: a frame opens with a low start bit
    a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> !ser_out);
    // R5: the line idles high between frames
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);
    // R5: no new byte is offered during a frame
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R6: the bit counter stays inside one bit period
    a_r6_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= CW'(BIT_DIV - 1)));
    // R8: completion is reported only once the frame is over
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/fb_line_seq.sv
// Module: character sequencer for one text line at a time.
// It picks word text or decimal digits with leading zeros removed, then CR and LF.
// It starts the transmitter for each character and waits for done. After the LF it
// either pulses advance or, at the last number, parks in the finished state.
module fb_line_seq #(
    parameter int DIGITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIGITS-1:0][3:0] digits,
    input  logic                   div3,
    input  logic                   div5,
    input  logic                   at_last,
    input  logic                   tx_done,
    output logic                   tx_start,
    output logic [7:0]             tx_data,
    output logic                   advance,
    output logic                   finished
);
    import fb_pkg::*;

    localparam int MAXLEN = (DIGITS > 8) ? DIGITS : 8;
    localparam int IW     = $clog2(MAXLEN + 2);

    typedef enum logic [1:0] {SQ_SEND, SQ_WAIT, SQ_DONE} seq_state_t;

    seq_state_t  state_q;
    logic [IW-1:0] idx_q;
    line_kind_t  kind;
    int          ndig;
    int          text_len;
    logic        line_end;
    logic [3:0]  sel_digit;

    // Choose the character for the current position of the line.
    always_comb begin
        if (div3 && div5) kind = LINE_BOTH;
        else if (div3)    kind = LINE_FIZZ;
        else if (div5)    kind = LINE_BUZZ;
        else              kind = LINE_NUM;

        ndig = 1;
        for (int d = 1; d < DIGITS; d++) begin
            if (digits[d] != 4'd0) ndig = d + 1;
        end

        case (kind)
            LINE_NUM:  text_len = ndig;
            LINE_BOTH: text_len = 8;
            default:   text_len = 4;
        endcase

        sel_digit = 4'd0;
        for (int d = 0; d < DIGITS; d++) begin
            if (d == ndig - 1 - int'(idx_q)) sel_digit = digits[d];
        end

        line_end = (int'(idx_q) == text_len + 1);
        if (int'(idx_q) < text_len) begin
            case (kind)
                LINE_NUM:  tx_data = {4'b0011, sel_digit};
                LINE_BUZZ: tx_data = word_char(int'(idx_q) + 4);
                default:   tx_data = word_char(int'(idx_q));
            endcase
        end else if (int'(idx_q) == text_len) begin
            tx_data = ASCII_CR;
        end else begin
            tx_data = ASCII_LF;
        end
    end

    // Step through characters and lines, waiting on each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_SEND;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SQ_SEND: state_q <= SQ_WAIT;
                SQ_WAIT: if (tx_done) begin
                    if (line_end && at_last) begin
                        state_q <= SQ_DONE;
                    end else begin
                        idx_q   <= line_end ? '0 : idx_q + 1'b1;
                        state_q <= SQ_SEND;
                    end
                end
                default: state_q <= SQ_DONE;
            endcase
        end
    end

    assign tx_start = (state_q == SQ_SEND);
    assign advance  = (state_q == SQ_WAIT) && tx_done && line_end && !at_last;
    assign finished = (state_q == SQ_DONE);

    // R7: once finished, the block stays finished
    a_r7_hold_finished: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> finished);
    // R7: no character is requested after the end
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !tx_start);
    // R4: a line is closed only on the line feed
    a_r4_lf_closes: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (tx_data == ASCII_LF));
endmodule

// File: rtl/fizzbuzz_serial_gen.sv
// Module: FizzBuzz serial text generator, top level.
// It holds the number in BCD with mod-3 and mod-5 residues, runs the line
// sequencer and drives an 8N1 transmitter. Assumes BIT_DIV >= 2 and that
// LAST_NUM fits in DIGITS decimal digits.
module fizzbuzz_serial_gen #(
    parameter int BIT_DIV  = 5208,
    parameter int DIGITS   = 3,
    parameter int LAST_NUM = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic ser_out,
    output logic busy,
    output logic finished
);
    logic [DIGITS-1:0][3:0] digits;
    logic [DIGITS-1:0]      dig_eq;
    logic                   div3, div5, at_last, advance;
    logic                   tx_start, tx_done;
    logic [7:0]             tx_data;

    for (genvar d = 0; d < DIGITS; d++) begin : g_last
        localparam int DV = (LAST_NUM / (10 ** d)) % 10;
        assign dig_eq[d] = (digits[d] == 4'(DV));
    end
    assign at_last = &dig_eq;

    fb_bcd_counter #(.DIGITS(DIGITS)) u_number (
        .clk(clk), .rst_n(rst_n), .inc(advance), .digit_q(digits));

    fb_residue #(.MOD(3), .INIT(1)) u_mod3 (
        .clk(clk), .rst_n(rst_n), .inc(advance), .is_zero(div3));

    fb_residue #(.MOD(5), .INIT(1)) u_mod5 (
        .clk(clk), .rst_n(rst_n), .inc(advance), .is_zero(div5));

    fb_line_seq #(.DIGITS(DIGITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .digits(digits), .div3(div3), .div5(div5),
        .at_last(at_last), .tx_done(tx_done), .tx_start(tx_start),
        .tx_data(tx_data), .advance(advance), .finished(finished));

    fb_uart_tx #(.BIT_DIV(BIT_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_data),
        .ser_out(ser_out), .busy(busy), .done(tx_done));

    // R8: nothing is on the line after the end
    a_r8_idle_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (!busy && ser_out));
endmodule

// File: tb/fizzbuzz_serial_gen_bench.sv
`timescale 1ns/1ps
// Bench: a scoreboard for the FizzBuzz generator. A driver task queues the expected
// characters and a monitor decodes frames at the pin and compares them.
module fizzbuzz_serial_gen_bench;
    localparam int DIV  = 5;
    localparam int LAST = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_out, busy, finished;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int  checks = 0;
    int  errors = 0;
    bit  watching = 0;
    bit  stop_when_empty = 0;
    bit  in_frame = 0;

    always #2.5 clk = ~clk;

    fizzbuzz_serial_gen #(.BIT_DIV(DIV), .DIGITS(3), .LAST_NUM(LAST)) u_fizzbuzz_serial_gen (
        .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .busy(busy), .finished(finished));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push_text(input string s, input string req);
        for (int i = 0; i < s.len(); i++) begin
            exp_q.push_back(s[i]);
            tag_q.push_back(req);
        end
    endtask

    // Driver: queue the expected characters of one line.
    task automatic push_line(input int n);
        if (n % 15 == 0)     push_text("FizzBuzz", "R2");
        else if (n % 3 == 0) push_text("Fizz", "R2");
        else if (n % 5 == 0) push_text("Buzz", "R2");
        else                 push_text($sformatf("%0d", n), "R3");
        push_text("\r\n", "R4");
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: decode each frame and compare it with the scoreboard.
    initial begin
        logic [9:0] bits;
        logic       first;
        forever begin
            @(negedge clk);
            if (watching && rst_n && !ser_out) begin
                in_frame = 1;
                check(finished == 1'b0, "R7", "finished during frame", finished, 0);
                for (int j = 0; j < 10; j++) begin
                    for (int c = 0; c < DIV; c++) begin
                        if (!(j == 0 && c == 0)) @(negedge clk);
                        if (c == 0) first = ser_out;
                        if (c == DIV / 2) begin
                            bits[j] = ser_out;
                            check(busy == 1'b1, "R8", "busy in frame", busy, 1);
                        end
                        if (c == DIV - 1)
                            check(ser_out == first, "R6", $sformatf("bit %0d steady", j), ser_out, first);
                    end
                end
                check(bits[0] == 1'b0, "R5", "start bit", bits[0], 0);
                check(bits[9] == 1'b1, "R5", "stop bit", bits[9], 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected frame", bits[8:1], 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bits[8:1] == e, t, "character", bits[8:1], e);
                end
                if (stop_when_empty && exp_q.size() == 0) watching = 0;
                in_frame = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ser_out == 1'b1, "R1", "ser_out in reset", ser_out, 1);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(finished == 1'b0, "R1", "finished in reset", finished, 0);
        for (int n = 1; n <= LAST; n++) push_line(n);
        watching = 1;
        rst_n = 1'b1;
        @(negedge clk);
        check(finished == 1'b0, "R1", "finished after release", finished, 0);

        while (exp_q.size() != 0 || in_frame) @(negedge clk);
        repeat (200) @(negedge clk);
        // R7 / R8: quiet after the last line
        check(finished == 1'b1, "R7", "finished at end", finished, 1);
        check(ser_out == 1'b1, "R7", "line high at end", ser_out, 1);
        check(busy == 1'b0, "R8", "busy at end", busy, 0);

        // R9: reset clears finished, then a restart runs from 1
        watching = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(finished == 1'b0, "R9", "finished cleared by reset", finished, 0);
        check(ser_out == 1'b1, "R9", "line high in reset", ser_out, 1);
        for (int n = 1; n <= 5; n++) push_line(n);
        stop_when_empty = 1;
        watching = 1;
        rst_n = 1'b1;
        while (watching) @(negedge clk);
        // R9: reset in the middle of the run, then another restart
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ser_out == 1'b1 && busy == 1'b0, "R9", "mid-run reset idles line",
              {ser_out, busy}, 2'b10);
        push_line(1);
        watching = 1;
        rst_n = 1'b1;
        while (watching) @(negedge clk);
        summary();
    end
endmodule